// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the 16-bit status word of a serial NOR flash model. It also decides whether a write-type command is allowed to run. An SPI front end decodes commands and gives the block one-cycle strobes: write enable, write disable, status write (with its data word), program/erase start and auto-increment program start. An internal array sequencer gives a strobe when an operation completes. It gives a second strobe when auto-increment programming reaches the top of the unprotected space.

The block tracks the busy flag, the write-enable latch, the auto-increment mode flag, the three protection-level bits, the protection lock and the quad-enable bit. It packs them into the status word at fixed positions. It grants or rejects each start request in the same cycle. A rejected start leaves the state unchanged. Every stored bit is volatile. Reset brings the part up with the whole array protected.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x001C: busy (bit 0) = 0, write-enable latch (bit 1) = 0, protection level (bits 4:2) = 3'b111, auto-increment flag (bit 6) = 0, lock (bit 7) = 0, quad enable (bit 9) = 0.
- R2: Bits 5, 8 and 15:10 always read 0, even after a status write with those data bits set.
- R3: An accepted status write copies data bits 4:2, 7 and 9 into the protection level, lock and quad-enable fields. It never changes busy, the latch or the auto-increment flag from data.
- R4: While lock (bit 7) is 1, a status write leaves bits 4:2 unchanged. The lock and quad-enable bits are still written, and the lock value from before the write decides.
- R5: A write-enable strobe sets the latch on the next clock when busy is 0. It is ignored while busy is 1.
- R6: The latch clears on the next clock after an accepted write-disable, after an accepted status write, or after completion of a program or erase started outside auto-increment mode.
- R7: An accepted auto-increment start sets busy and the auto-increment flag. A completion while in that mode clears busy and keeps the latch. The end-of-range strobe clears the flag and the latch. An accepted write-disable also leaves the mode.
- R8: A program/erase start with the latch at 0 raises the reject output in the same cycle. It leaves busy at 0.
- R9: A granted start sets busy on the next clock. Busy stays 1 until a completion strobe, and clears on the clock after that strobe. A completion while not busy is ignored.
- R10: While busy is 1, status write, write-enable and write-disable strobes leave the status word unchanged.
- R11: A program/erase start while the auto-increment flag is 1 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| wr_data | input | 16 | Data word for the status write |
| pe_start | input | 1 | Program or erase start request |
| aai_start | input | 1 | Auto-increment program start request |
| op_done | input | 1 | Sequencer completion strobe |
| aai_end | input | 1 | Auto-increment reached the top of the unprotected range |
| status | output | 16 | Packed status word |
| busy | output | 1 | Internal operation in progress |
| wel | output | 1 | Write-enable latch |
| pe_grant | output | 1 | Program/erase start accepted (same cycle) |
| pe_reject | output | 1 | Program/erase start refused (same cycle) |
| aai_grant | output | 1 | Auto-increment start accepted (same cycle) |
| aai_reject | output | 1 | Auto-increment start refused (same cycle) |

## Verification
Status writes are tried with all-ones and all-zeros data, with lock set and with lock clear. These cases separate the writable fields from the read-only and reserved ones, and show whether the lock is sampled before or after the write. Start requests are sent with the latch clear, with the latch set, and in auto-increment mode, so a wrong gating term shows up as a wrong grant. Commands are also sent while busy, to catch any update that leaks through the busy gate. Each clearing event for the latch is run on its own: write-disable, status write, normal completion, end of range, and a completion inside auto-increment mode that must not clear it.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int STATUS_W = 16;
  localparam int BP_W     = 3;
  localparam int POS_BUSY = 0;
  localparam int POS_WEL  = 1;
  localparam int POS_BP   = 2;
  localparam int POS_AAI  = 6;
  localparam int POS_LOCK = 7;
  localparam int POS_QE   = 9;
  localparam logic [BP_W-1:0] BP_RESET = '1;

  // Build the status word from its fields; unlisted bits stay zero.
  function automatic logic [STATUS_W-1:0] pack_status(
    input logic            b, input logic w, input logic [BP_W-1:0] bp,
    input logic            a, input logic l, input logic q);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[POS_BUSY] = b;
    s[POS_WEL]  = w;
    s[POS_BP +: BP_W] = bp;
    s[POS_AAI]  = a;
    s[POS_LOCK] = l;
    s[POS_QE]   = q;
    return s;
  endfunction

  // Protection level after a status write, given the lock before it.
  function automatic logic [BP_W-1:0] next_bp(
    input logic [BP_W-1:0] cur, input logic [BP_W-1:0] req, input logic locked);
    return locked ? cur : req;
  endfunction
endpackage

// File: rtl/fsr_wel_latch.sv
module fsr_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (clr_ev) wel <= 1'b0;
    else if (set_ev) wel <= 1'b1;
  end

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !wel);
  a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !clr_ev) |=> wel);
endmodule

// File: rtl/fsr_prot_bits.sv
module fsr_prot_bits
  import flash_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_take,
  input  logic [BP_W-1:0] wr_bp,
  input  logic            wr_lock,
  input  logic            wr_qe,
  output logic [BP_W-1:0] bp,
  output logic            lock,
  output logic            qe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp   <= BP_RESET;
      lock <= 1'b0;
      qe   <= 1'b0;
    end else if (wr_take) begin
      bp   <= next_bp(bp, wr_bp, lock);
      lock <= wr_lock;
      qe   <= wr_qe;
    end
  end

  a_r4_lock_freezes_bp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && lock) |=> $stable(bp));
  a_r3_fields_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (lock == $past(wr_lock)) && (qe == $past(wr_qe)));
endmodule

// File: rtl/fsr_op_track.sv
module fsr_op_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pe_go,
  input  logic aai_go,
  input  logic op_done,
  input  logic aai_end,
  input  logic aai_exit,
  output logic busy,
  output logic aai
);
  logic start_ev;
  assign start_ev = pe_go | aai_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (start_ev) busy <= 1'b1;
    else if (op_done)  busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   aai <= 1'b0;
    else if (aai_go)              aai <= 1'b1;
    else if (aai_end || aai_exit) aai <= 1'b0;
  end

  a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done && !start_ev) |=> !busy);
  a_r7_aai_enters: assert property (@(posedge clk) disable iff (!rst_n)
    aai_go |=> aai);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wren,
  input  logic                cmd_wrdi,
  input  logic                cmd_wrsr,
  input  logic [STATUS_W-1:0] wr_data,
  input  logic                pe_start,
  input  logic                aai_start,
  input  logic                op_done,
  input  logic                aai_end,
  output logic [STATUS_W-1:0] status,
  output logic                busy,
  output logic                wel,
  output logic                pe_grant,
  output logic                pe_reject,
  output logic                aai_grant,
  output logic                aai_reject
);
  logic            idle;
  logic            aai_q;
  logic            wren_take, wrdi_take, wrsr_take;
  logic            normal_done;
  logic            wel_set, wel_clr;
  logic [BP_W-1:0] bp_q;
  logic            lock_q, qe_q;
  logic            unused_bits;

  // Reserved data bits have no destination.
  assign unused_bits = ^{wr_data[STATUS_W-1:POS_QE+1], wr_data[POS_QE-1],
                         wr_data[POS_AAI-1:POS_BP+BP_W], wr_data[POS_AAI],
                         wr_data[POS_WEL:POS_BUSY]};

  // Named internal events.
  assign idle        = !busy;
  assign wren_take   = cmd_wren & idle;
  assign wrdi_take   = cmd_wrdi & idle;
  assign wrsr_take   = cmd_wrsr & idle;
  assign normal_done = op_done & busy & !aai_q;

  assign pe_grant    = pe_start & wel & idle & !aai_q;
  assign pe_reject   = pe_start & !pe_grant;
  assign aai_grant   = aai_start & wel & idle;
  assign aai_reject  = aai_start & !aai_grant;

  assign wel_set = wren_take;
  assign wel_clr = wrdi_take | wrsr_take | normal_done | aai_end;

  fsr_wel_latch u_wel (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (wel_set),
    .clr_ev (wel_clr),
    .wel    (wel)
  );

  fsr_prot_bits u_prot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_take (wrsr_take),
    .wr_bp   (wr_data[POS_BP +: BP_W]),
    .wr_lock (wr_data[POS_LOCK]),
    .wr_qe   (wr_data[POS_QE]),
    .bp      (bp_q),
    .lock    (lock_q),
    .qe      (qe_q)
  );

  fsr_op_track u_ops (
    .clk      (clk),
    .rst_n    (rst_n),
    .pe_go    (pe_grant),
    .aai_go   (aai_grant),
    .op_done  (op_done),
    .aai_end  (aai_end),
    .aai_exit (wrdi_take),
    .busy     (busy),
    .aai      (aai_q)
  );

  assign status = pack_status(busy, wel, bp_q, aai_q, lock_q, qe_q);

  a_r8_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_grant || aai_grant) |-> (wel && !busy));
  a_r11_no_pe_in_aai: assert property (@(posedge clk) disable iff (!rst_n)
    aai_q |-> !pe_grant);
  a_r10_busy_freezes_prot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bp_q) && $stable(lock_q) && $stable(qe_q)));
  a_r5_busy_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel) |=> !wel);
endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
  logic [15:0] wr_data = '0;
  logic        pe_start = 0, aai_start = 0, op_done = 0, aai_end = 0;
  logic [15:0] status;
  logic        busy, wel, pe_grant, pe_reject, aai_grant, aai_reject;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] val;
    int          due;
    string       tag;
  } item_t;
  item_t sb[$];

  // bench model of the fields
  logic       m_busy = 0, m_wel = 0, m_aai = 0, m_lock = 0, m_qe = 0;
  logic [2:0] m_bp = 3'b111;

  flash_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wr_data(wr_data), .pe_start(pe_start),
    .aai_start(aai_start), .op_done(op_done), .aai_end(aai_end),
    .status(status), .busy(busy), .wel(wel), .pe_grant(pe_grant),
    .pe_reject(pe_reject), .aai_grant(aai_grant), .aai_reject(aai_reject)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word();
    return {6'b0, m_qe, 1'b0, m_lock, m_aai, 1'b0, m_bp, m_wel, m_busy};
  endfunction

  // monitor: compares scoreboard entries once their cycle has passed
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, {16'b0, status}, {16'b0, it.val});
    end
  end

  // driver: one command cycle, model update, expected push
  task automatic step(input logic wren, input logic wrdi, input logic wrsr,
                      input logic [15:0] d, input logic pe, input logic ai,
                      input logic dn, input logic ae, input string tag);
    logic idle, pe_g, ai_g, clr, nwel, nbusy, naai;
    item_t it;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; wr_data = d;
    pe_start = pe; aai_start = ai; op_done = dn; aai_end = ae;
    #1;
    idle = !m_busy;
    pe_g = pe && m_wel && idle && !m_aai;
    ai_g = ai && m_wel && idle;
    if (pe) begin
      chk({tag, " pe_grant"}, {31'b0, pe_grant}, {31'b0, pe_g});
      chk({tag, " pe_reject"}, {31'b0, pe_reject}, {31'b0, !pe_g});
    end
    if (ai) chk({tag, " aai_grant"}, {31'b0, aai_grant}, {31'b0, ai_g});
    clr   = (wrdi && idle) || (wrsr && idle) || (dn && m_busy && !m_aai) || ae;
    nwel  = clr ? 1'b0 : ((wren && idle) ? 1'b1 : m_wel);
    nbusy = (pe_g || ai_g) ? 1'b1 : (dn ? 1'b0 : m_busy);
    naai  = ai_g ? 1'b1 : ((ae || (wrdi && idle)) ? 1'b0 : m_aai);
    if (wrsr && idle) begin
      if (!m_lock) m_bp = d[4:2];
      m_lock = d[7];
      m_qe   = d[9];
    end
    m_wel = nwel; m_busy = nbusy; m_aai = naai;
    it.val = model_word(); it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #1;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wr_data = '0;
    pe_start = 0; aai_start = 0; op_done = 0; aai_end = 0;
  endtask

  task automatic wren_c(input string t);  step(1,0,0,16'h0,0,0,0,0,t); endtask
  task automatic wrdi_c(input string t);  step(0,1,0,16'h0,0,0,0,0,t); endtask
  task automatic wrsr_c(input logic [15:0] d, input string t); step(0,0,1,d,0,0,0,0,t); endtask
  task automatic pe_c(input string t);    step(0,0,0,16'h0,1,0,0,0,t); endtask
  task automatic aai_c(input string t);   step(0,0,0,16'h0,0,1,0,0,t); endtask
  task automatic done_c(input logic ae, input string t); step(0,0,0,16'h0,0,0,1,ae,t); endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", {16'b0, status}, 32'h001C);
    chk("R1 reset busy/wel", {30'b0, busy, wel}, 32'h0);

    wrsr_c(16'hFFFF, "R2 R3 write all ones");       // 0x029C
    wrsr_c(16'h0000, "R4 locked write keeps bp");   // 0x001C
    wrsr_c(16'h0000, "R3 unlocked write clears bp");// 0x0000
    pe_c("R8 start without latch");
    aai_c("R8 aai without latch");
    wren_c("R5 write enable");
    wrsr_c(16'h0008, "R6 status write clears latch");
    wren_c("R5 write enable again");
    wrdi_c("R6 write disable clears latch");
    wren_c("R5 enable before program");
    pe_c("R9 program granted");
    wrsr_c(16'hFFFF, "R10 status write while busy");
    wrdi_c("R10 write disable while busy");
    done_c(0, "R6 R9 completion clears busy and latch");
    done_c(0, "R9 completion while idle ignored");
    wren_c("R5 enable for busy test");
    pe_c("R9 erase granted");
    wren_c("R5 R10 enable ignored while busy");
    done_c(0, "R6 erase completion");
    wren_c("R10 enable after busy cleared");
    pe_c("R9 start");
    done_c(0, "R6 completion");
    wren_c("R7 enable for aai");
    aai_c("R7 aai start");
    done_c(0, "R7 word done keeps latch");
    pe_c("R11 program in aai mode rejected");
    aai_c("R7 next aai word");
    done_c(1, "R7 end of range clears flag and latch");
    wren_c("R7 enable again");
    aai_c("R7 aai start again");
    done_c(0, "R7 word done");
    wrdi_c("R7 write disable leaves aai");
    wrsr_c(16'hFC60, "R2 reserved bits only");

    repeat (4) @(negedge clk);
    chk("R2 final scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule